// File: doc/BRIEF.md
# Backplane Command Bus Driver

This block drives two command paths onto a crate backplane. The broadcast path carries a 6-bit command code together with a bunch-counter reset line, an event-counter reset line and a command strobe. The individual path carries an 8-bit data byte with its own data strobe. No dedicated function pulses are sent on either path. A receiving board works out functions such as bunch-crossing zero from the command code whenever the strobe is high.

Each path takes commands from two sources. The first is the parallel outputs of a timing receiver. The second is an emulation port that control software writes in order to stand in for that receiver. The emulation port can also set a group of spare backplane lines to static levels.

Every command passes through one register stage before it reaches the bus. A strobe therefore appears exactly one clock after its command is accepted, and it lasts one clock per command. If both sources present a command to the same path in the same cycle, the receiver's command is sent, the emulated one is dropped, and an overrun flag marks that strobe cycle.

The emulation port uses a valid/ready handshake. `emu_ready` is always high, so the port never applies back-pressure. A command that loses a collision is still consumed when it is dropped, and it is reported only through the overrun flag.

A reference receiver-side decoder watches the driven bus. It raises a bunch-crossing-zero flag so the behaviour a receiving board sees can be checked.

Top module: `cmdbus_driver`

## Requirements
- R1: A receiver broadcast command (`rx_bc_strb` high) appears on `bp_cmd`, `bp_bcnt_res` and `bp_evcnt_res`, with `bp_cmd_strb` high, in the cycle after it is sampled.
- R2: A receiver individual command (`rx_ind_strb` high) appears on `bp_data`, with `bp_data_strb` high, in the cycle after it is sampled. It is independent of the broadcast path.
- R3: An accepted emulation write reaches the bus one cycle later. The `emu_kind` codes are: 0 = broadcast, 1 = individual, 2 = spare lines, 3 = no operation. For a broadcast write, `emu_payload` bits [5:0] are the command code, bit 6 is the bunch-counter reset and bit 7 is the event-counter reset. For an individual write, bits [7:0] are the data byte.
- R4: When the receiver and the emulation port target the same path in the same cycle, the receiver's command is driven. The overrun flag for that path (`ovr_bcast` or `ovr_indiv`) is high in the same cycle as the resulting strobe, and low in every other cycle.
- R5: A spare write (kind 2) sets `bp_spare` to `emu_payload[3:0]` one cycle later. The lines keep that value until the next spare write.
- R6: `dec_bc0` goes high one cycle after a bus cycle in which `bp_cmd_strb` is high and `bp_cmd` equals 0x01. A code of 0x01 presented without a strobe does not raise it.
- R7: While `rst_n` is low, every output except `emu_ready` is zero, including both strobes and the spare lines.
- R8: Each accepted command produces exactly one strobe cycle. In any cycle that follows a cycle with no command for that path, the strobe and that path's fields are zero.
- R9: An emulation write of kind 3 changes no output. `emu_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bc_cmd | input | 6 | Receiver broadcast command code |
| rx_bc_bcnt_res | input | 1 | Receiver bunch-counter reset |
| rx_bc_evcnt_res | input | 1 | Receiver event-counter reset |
| rx_bc_strb | input | 1 | Receiver broadcast strobe |
| rx_ind_data | input | 8 | Receiver individual data byte |
| rx_ind_strb | input | 1 | Receiver individual strobe |
| emu_valid | input | 1 | Emulation write valid |
| emu_ready | output | 1 | Emulation write ready (always high) |
| emu_kind | input | 2 | Emulation target selector |
| emu_payload | input | 8 | Emulation write payload |
| bp_cmd | output | 6 | Backplane broadcast command |
| bp_bcnt_res | output | 1 | Backplane bunch-counter reset |
| bp_evcnt_res | output | 1 | Backplane event-counter reset |
| bp_cmd_strb | output | 1 | Backplane command strobe |
| bp_data | output | 8 | Backplane individual data |
| bp_data_strb | output | 1 | Backplane data strobe |
| bp_spare | output | 4 | Spare backplane lines |
| ovr_bcast | output | 1 | Broadcast collision flag |
| ovr_indiv | output | 1 | Individual collision flag |
| dec_bc0 | output | 1 | Reference decoder bunch-crossing-zero flag |

## Verification
The bench builds the block with its default parameters: a 6-bit code, an 8-bit data byte, 4 spare lines and a bunch-crossing-zero code of 0x01. With these values the emulation payload is exactly 8 bits wide, so every payload bit matters for one of the targets. This lets the bench hit the cases where the command code and both counter-reset bits all share one write. It also covers a code of 0x01 sent with and without a strobe, same-cycle collisions on each path on its own and on both paths together, and back-to-back strobes.

// File: rtl/cmdbus_pkg.sv
package cmdbus_pkg;
  typedef enum logic [1:0] {
    EMU_BCAST = 2'd0,
    EMU_INDIV = 2'd1,
    EMU_SPARE = 2'd2,
    EMU_NOP   = 2'd3
  } emu_kind_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/cmdbus_path.sv
module cmdbus_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         live_v,
  input  logic [W-1:0] live_d,
  input  logic         emu_v,
  input  logic [W-1:0] emu_d,
  output logic         out_strb,
  output logic [W-1:0] out_d,
  output logic         out_ovr
);
  logic [W-1:0] pick_d;

  // receiver has priority over emulation; idle bus carries zeros
  always_comb begin
    if (live_v)     pick_d = live_d;
    else if (emu_v) pick_d = emu_d;
    else            pick_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_strb <= 1'b0;
      out_d    <= '0;
      out_ovr  <= 1'b0;
    end else begin
      out_strb <= live_v | emu_v;
      out_d    <= pick_d;
      out_ovr  <= live_v & emu_v;
    end
  end

  AST_LIVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    live_v |=> (out_strb && out_d == $past(live_d))); // R4
  AST_OVR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovr |-> out_strb); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_v && !emu_v) |=> (!out_strb && out_d == '0)); // R8
endmodule

// File: rtl/cmdbus_spare.sv
module cmdbus_spare #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= d;
  end

  AST_SPARE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q)); // R5
endmodule

// File: rtl/cmdbus_refdec.sv
module cmdbus_refdec #(
  parameter int          CMD_W    = 6,
  parameter logic [CMD_W-1:0] BC0_CODE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb,
  input  logic [CMD_W-1:0] cmd,
  output logic             bc0
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bc0 <= 1'b0;
    else        bc0 <= strb && (cmd == BC0_CODE);
  end
endmodule

// File: rtl/cmdbus_driver.sv
module cmdbus_driver
  import cmdbus_pkg::*;
#(
  parameter int CMD_W    = 6,
  parameter int DATA_W   = 8,
  parameter int SPARE_W  = 4,
  parameter int BC0_CODE = 1,
  localparam int BC_W    = CMD_W + 2,
  localparam int EMU_W   = max3(BC_W, DATA_W, SPARE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CMD_W-1:0]   rx_bc_cmd,
  input  logic               rx_bc_bcnt_res,
  input  logic               rx_bc_evcnt_res,
  input  logic               rx_bc_strb,
  input  logic [DATA_W-1:0]  rx_ind_data,
  input  logic               rx_ind_strb,
  input  logic               emu_valid,
  output logic               emu_ready,
  input  logic [1:0]         emu_kind,
  input  logic [EMU_W-1:0]   emu_payload,
  output logic [CMD_W-1:0]   bp_cmd,
  output logic               bp_bcnt_res,
  output logic               bp_evcnt_res,
  output logic               bp_cmd_strb,
  output logic [DATA_W-1:0]  bp_data,
  output logic               bp_data_strb,
  output logic [SPARE_W-1:0] bp_spare,
  output logic               ovr_bcast,
  output logic               ovr_indiv,
  output logic               dec_bc0
);
  logic            acc;
  logic            emu_bc_v, emu_ind_v, emu_sp_v;
  logic [BC_W-1:0] rx_bc_word, bp_bc_word;

  // never stalls: a collision drops the emulated word and flags it
  assign emu_ready = 1'b1;
  assign acc       = emu_valid & emu_ready;
  assign emu_bc_v  = acc && (emu_kind == EMU_BCAST);
  assign emu_ind_v = acc && (emu_kind == EMU_INDIV);
  assign emu_sp_v  = acc && (emu_kind == EMU_SPARE);

  assign rx_bc_word = {rx_bc_evcnt_res, rx_bc_bcnt_res, rx_bc_cmd};

  cmdbus_path #(.W(BC_W)) u_bc (
    .clk(clk), .rst_n(rst_n),
    .live_v(rx_bc_strb), .live_d(rx_bc_word),
    .emu_v(emu_bc_v), .emu_d(emu_payload[BC_W-1:0]),
    .out_strb(bp_cmd_strb), .out_d(bp_bc_word), .out_ovr(ovr_bcast)
  );

  assign bp_cmd       = bp_bc_word[CMD_W-1:0];
  assign bp_bcnt_res  = bp_bc_word[CMD_W];
  assign bp_evcnt_res = bp_bc_word[CMD_W+1];

  cmdbus_path #(.W(DATA_W)) u_ind (
    .clk(clk), .rst_n(rst_n),
    .live_v(rx_ind_strb), .live_d(rx_ind_data),
    .emu_v(emu_ind_v), .emu_d(emu_payload[DATA_W-1:0]),
    .out_strb(bp_data_strb), .out_d(bp_data), .out_ovr(ovr_indiv)
  );

  cmdbus_spare #(.W(SPARE_W)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .wr(emu_sp_v), .d(emu_payload[SPARE_W-1:0]), .q(bp_spare)
  );

  cmdbus_refdec #(.CMD_W(CMD_W), .BC0_CODE(CMD_W'(BC0_CODE))) u_dec (
    .clk(clk), .rst_n(rst_n),
    .strb(bp_cmd_strb), .cmd(bp_cmd), .bc0(dec_bc0)
  );

  AST_BC0_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_bc0 |-> $past(bp_cmd_strb)); // R6
  AST_NOP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_valid && emu_kind == EMU_NOP && !rx_bc_strb && !rx_ind_strb)
      |=> (!bp_cmd_strb && !bp_data_strb && $stable(bp_spare))); // R9
  AST_OVR_INDIV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_indiv |-> $past(rx_ind_strb && emu_valid)); // R4
endmodule

// File: tb/sim_cmdbus_driver.sv
module sim_cmdbus_driver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] rx_bc_cmd = '0;
  logic       rx_bc_bcnt_res = 1'b0, rx_bc_evcnt_res = 1'b0, rx_bc_strb = 1'b0;
  logic [7:0] rx_ind_data = '0;
  logic       rx_ind_strb = 1'b0;
  logic       emu_valid = 1'b0;
  logic       emu_ready;
  logic [1:0] emu_kind = 2'd3;
  logic [7:0] emu_payload = '0;
  logic [5:0] bp_cmd;
  logic       bp_bcnt_res, bp_evcnt_res, bp_cmd_strb;
  logic [7:0] bp_data;
  logic       bp_data_strb;
  logic [3:0] bp_spare;
  logic       ovr_bcast, ovr_indiv, dec_bc0;

  cmdbus_driver u0 (.*);

  always #10 clk = ~clk;

  typedef struct {
    int         due;
    string      tag;
    logic [5:0] cmd;
    logic       bcnt, evcnt, cs;
    logic [7:0] data;
    logic       ds;
    logic [3:0] spare;
    logic       ob, oi, bc0;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0, bad = 0;
  logic [3:0] spare_m = '0;
  logic       prev_bc0 = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares outputs at the negedge of the cycle each item is due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "cmd_strb", 32'(bp_cmd_strb), 32'(e.cs));
      chk(e.tag, "cmd", 32'(bp_cmd), 32'(e.cmd));
      chk(e.tag, "bcnt", 32'(bp_bcnt_res), 32'(e.bcnt));
      chk(e.tag, "evcnt", 32'(bp_evcnt_res), 32'(e.evcnt));
      chk(e.tag, "data_strb", 32'(bp_data_strb), 32'(e.ds));
      chk(e.tag, "data", 32'(bp_data), 32'(e.data));
      chk(e.tag, "spare", 32'(bp_spare), 32'(e.spare));
      chk(e.tag, "ovr_bcast", 32'(ovr_bcast), 32'(e.ob));
      chk(e.tag, "ovr_indiv", 32'(ovr_indiv), 32'(e.oi));
      chk(e.tag, "dec_bc0", 32'(dec_bc0), 32'(e.bc0));
      chk(e.tag, "emu_ready", 32'(emu_ready), 32'd1);
    end
  end

  // driver: applies one cycle of stimulus and queues the expected bus state
  task automatic drive(string tag,
                       logic bs, logic [5:0] bcmd, logic bb, logic be,
                       logic is, logic [7:0] idat,
                       logic ev, logic [1:0] kind, logic [7:0] pay);
    exp_t e;
    logic eb, ei;
    eb = ev && kind == 2'd0;
    ei = ev && kind == 2'd1;
    e.due   = cyc + 1;
    e.tag   = tag;
    e.cs    = bs | eb;
    e.cmd   = bs ? bcmd : (eb ? pay[5:0] : 6'd0);
    e.bcnt  = bs ? bb   : (eb ? pay[6]   : 1'b0);
    e.evcnt = bs ? be   : (eb ? pay[7]   : 1'b0);
    e.ds    = is | ei;
    e.data  = is ? idat : (ei ? pay : 8'd0);
    e.ob    = bs && eb;
    e.oi    = is && ei;
    if (ev && kind == 2'd2) spare_m = pay[3:0];
    e.spare = spare_m;
    e.bc0   = prev_bc0;
    prev_bc0 = e.cs && e.cmd == 6'h01;
    rx_bc_strb = bs; rx_bc_cmd = bcmd; rx_bc_bcnt_res = bb; rx_bc_evcnt_res = be;
    rx_ind_strb = is; rx_ind_data = idat;
    emu_valid = ev; emu_kind = kind; emu_payload = pay;
    q.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) drive(tag, 0, 6'h3F, 1, 1, 0, 8'hFF, 0, 2'd0, 8'hFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: outputs zero during reset
    chk("R7", "reset bus", {bp_cmd_strb, bp_data_strb, bp_cmd, bp_data, bp_spare,
        ovr_bcast, ovr_indiv, dec_bc0, bp_bcnt_res, bp_evcnt_res}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    idle("R8", 2);
    // R1: live broadcast patterns
    drive("R1", 1, 6'h2A, 1, 0, 0, 8'h00, 0, 2'd0, 8'h00);
    drive("R1", 1, 6'h15, 0, 1, 0, 8'h00, 0, 2'd0, 8'h00);
    idle("R8", 1);
    // R2: live individual, then both paths in one cycle
    drive("R2", 0, 6'h00, 0, 0, 1, 8'hA5, 0, 2'd0, 8'h00);
    drive("R2", 1, 6'h33, 1, 1, 1, 8'h5A, 0, 2'd0, 8'h00);
    idle("R8", 1);
    // R3: emulated broadcast and individual
    drive("R3", 0, 6'h00, 0, 0, 0, 8'h00, 1, 2'd0, 8'hC7);
    drive("R3", 0, 6'h00, 0, 0, 0, 8'h00, 1, 2'd1, 8'h3C);
    drive("R3", 1, 6'h09, 0, 0, 0, 8'h00, 1, 2'd1, 8'h81);
    idle("R8", 1);
    // R4: collisions on each path
    drive("R4", 1, 6'h12, 0, 1, 0, 8'h00, 1, 2'd0, 8'hFF);
    drive("R4", 0, 6'h00, 0, 0, 1, 8'h66, 1, 2'd1, 8'h99);
    drive("R4", 1, 6'h04, 1, 0, 1, 8'h11, 1, 2'd1, 8'hEE);
    idle("R4", 1);
    // R5: spare lines hold
    drive("R5", 0, 6'h00, 0, 0, 0, 8'h00, 1, 2'd2, 8'hFB);
    idle("R5", 3);
    drive("R5", 1, 6'h07, 0, 0, 0, 8'h00, 1, 2'd2, 8'h46);
    idle("R5", 2);
    // R6: bunch-crossing zero from live and emulated sources, not without strobe
    drive("R6", 1, 6'h01, 0, 0, 0, 8'h00, 0, 2'd0, 8'h00);
    idle("R6", 2);
    drive("R6", 0, 6'h01, 0, 0, 0, 8'h00, 0, 2'd0, 8'h00);
    idle("R6", 2);
    drive("R6", 0, 6'h00, 0, 0, 0, 8'h00, 1, 2'd0, 8'h01);
    drive("R6", 1, 6'h01, 0, 0, 0, 8'h00, 0, 2'd0, 8'h00);
    drive("R6", 1, 6'h02, 0, 0, 0, 8'h00, 0, 2'd0, 8'h00);
    idle("R6", 2);
    // R9: no-operation writes leave the bus untouched
    drive("R9", 0, 6'h00, 0, 0, 0, 8'h00, 1, 2'd3, 8'hFF);
    drive("R9", 0, 6'h00, 0, 0, 0, 8'h00, 1, 2'd3, 8'hA0);
    idle("R9", 2);
    // R8: back-to-back strobes then quiet
    drive("R8", 1, 6'h3E, 0, 0, 1, 8'h01, 0, 2'd0, 8'h00);
    drive("R8", 1, 6'h3D, 0, 0, 1, 8'h02, 0, 2'd0, 8'h00);
    idle("R8", 3);
    wait (q.size() == 0);
    @(negedge clk);
    // R7: asynchronous reset clears the bus, including the spare lines
    drive("R7", 0, 6'h00, 0, 0, 0, 8'h00, 1, 2'd2, 8'h0F);
    rx_bc_strb = 1'b1; rx_ind_strb = 1'b1; rx_bc_cmd = 6'h01; rx_ind_data = 8'hFF;
    @(posedge clk); #3;
    rst_n = 1'b0;
    #3;
    chk("R7", "reset bus", {bp_cmd_strb, bp_data_strb, bp_cmd, bp_data, bp_spare,
        ovr_bcast, ovr_indiv, dec_bc0, bp_bcnt_res, bp_evcnt_res}, 32'd0);
    @(negedge clk);
    chk("R7", "reset held", {bp_cmd_strb, bp_data_strb, bp_cmd, bp_data, bp_spare}, 32'd0);
    q.delete();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule